// File: doc/BRIEF.md
# Cache Parity Guard with Deliberate Error Injection

This block keeps a small word-wide data array for each of two cache sides: the instruction side and the data side. It stores one even-parity bit with every byte written. On each read it checks the stored parity against the data and raises a machine-check pulse on a mismatch. Each side has a control register with two bits. One bit enables checking. The other makes every qualifying write store all of its parity bits inverted. Error-recovery software can use this to plant a known-bad word and watch the machine-check path fire when that word is read back.

Writes come in four kinds: line fill, byte store, line zero and line allocate. The instruction side accepts only fills. The data side accepts all four. Reads return the word, its stored parity and a possible error pulse one cycle later. Tag lookup, replacement and coherency belong to other blocks.

Top module: `cache_parity_guard`

## Requirements
- R1: While `rst_n` is low and after its release, both control registers are zero, so checking and injection are off. Every array word holds zero data with zero parity, `rd_valid` and `mc_err` are low, and a read returns zero data and zero parity.
- R2: A control write (`csr_we`=1) loads the register chosen by `csr_side` (0 = instruction, 1 = data). `csr_wdata[0]` is the check enable. `csr_wdata[1]` is the inject request. The inject bit is stored as 1 only when bits 1 and 0 are both set in the same write; otherwise it is stored as 0.
- R3: Parity is even and kept per byte: parity bit b equals the XOR of data bits 8b+7..8b. A write made with injection off stores exactly that value.
- R4: While the instruction-side inject bit is set, a fill to the instruction side stores all four parity bits inverted. Store, zero and allocate writes to the instruction side change nothing.
- R5: While the data-side inject bit is set, a fill to the data side stores all four parity bits inverted.
- R6: While the data-side inject bit is set, store, zero and allocate writes store inverted parity for every byte they write.
- R7: `wr_kind` encodes 0 = fill, 1 = store, 2 = zero, 3 = allocate. Fill writes all four bytes of `wr_data`. Store writes only the bytes whose `wr_be` bit is set and leaves the other bytes and their parity unchanged. Zero and allocate write all four bytes as zero.
- R8: A read issued in cycle n (`rd_en`=1) gives `rd_valid`, `rd_data` and `rd_par` in cycle n+1. A write to the same index in cycle n is not yet visible to that read.
- R9: If the chosen side's check enable is set in the read cycle and the stored parity differs from the even parity of the stored data, `mc_err` pulses for one cycle together with `rd_valid`. In that cycle `mc_err_side` (0 = instruction, 1 = data) and `mc_err_idx` name the failing word.
- R10: A read from a side whose check enable is clear never raises `mc_err`, whatever the stored parity.
- R11: Injection affects only writes made while the inject bit is set. Changing the register later leaves stored parity as it was, so a planted bad word still errors once checking is on again, and a fresh fill with injection off repairs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Control register write strobe |
| csr_side | input | 1 | Register select, 0 instruction, 1 data |
| csr_wdata | input | 2 | Bit 0 check enable, bit 1 inject request |
| wr_en | input | 1 | Array write strobe |
| wr_side | input | 1 | Write side, 0 instruction, 1 data |
| wr_kind | input | 2 | 0 fill, 1 store, 2 zero, 3 allocate |
| wr_idx | input | 4 | Word index of the write |
| wr_data | input | 32 | Write data (fill and store) |
| wr_be | input | 4 | Byte enables for store |
| rd_en | input | 1 | Read strobe |
| rd_side | input | 1 | Read side |
| rd_idx | input | 4 | Word index of the read |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read data |
| rd_par | output | 4 | Stored parity of the read word |
| mc_err | output | 1 | Machine-check pulse on a detected mismatch |
| mc_err_side | output | 1 | Side of the last error |
| mc_err_idx | output | 4 | Word index of the last error |

## Verification
The hardest case to reach is a word whose parity does not match its data. The ports have no direct way to corrupt stored parity, so the only route is a write made while injection is armed. Arming it takes a control write with both bits set. The bench therefore plants bad words through fills, masked stores, zero and allocate writes. It then turns checking off and on again and reads those words back. This shows that the error follows the stored state, not the current inject setting. A long random phase mixes control writes, partial stores and reads that land on the index being written, and a behavioural model is compared against every clock.

// File: rtl/cpg_pkg.sv
// Package: shared write-kind encoding and side numbering for the parity guard.
// Assumes two cache sides, numbered instruction = 0, data = 1.
package cpg_pkg;
    typedef enum logic [1:0] {
        WK_FILL  = 2'd0,
        WK_STORE = 2'd1,
        WK_ZERO  = 2'd2,
        WK_ALLOC = 2'd3
    } wr_kind_e;

    localparam int SIDE_I    = 0;
    localparam int SIDE_D    = 1;
    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/cpg_csr.sv
// Module: the two per-side control registers (check enable, inject).
// The inject bit is accepted only when the same write also sets the check
// enable bit. Assumes one write per cycle, selected by csr_side.
module cpg_csr
    import cpg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_we,
    input  logic                 csr_side,
    input  logic [1:0]           csr_wdata,
    output logic [NUM_SIDES-1:0] chk_en,
    output logic [NUM_SIDES-1:0] inj_en
);
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        logic sel;
        assign sel = csr_we && (csr_side == s[0]);

        // Load this side's check and gated inject bits on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chk_en[s] <= 1'b0;
                inj_en[s] <= 1'b0;
            end else if (sel) begin
                chk_en[s] <= csr_wdata[0];
                inj_en[s] <= csr_wdata[1] & csr_wdata[0];
            end
        end
    end
endmodule

// File: rtl/cpg_bank.sv
// Module: one side's data array with per-byte parity storage.
// Computes even parity per byte on writes, inverting it while inject is set.
// Non-fill writes are dropped unless ALLOW_STORE is set. Reads are
// combinational from the array, so a same-cycle write is not yet visible.
module cpg_bank
    import cpg_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter bit ALLOW_STORE = 1'b1,
    localparam int BYTES      = DATA_W / 8,
    localparam int IDX_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTES-1:0]  be,
    input  logic              inject,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rdata,
    output logic [BYTES-1:0]  rpar
);
    logic [DATA_W-1:0] mem  [DEPTH];
    logic [BYTES-1:0]  pmem [DEPTH];

    wr_kind_e          kind_e;
    logic              accept;
    logic              zeroing;
    logic [BYTES-1:0]  byte_wr;
    logic [7:0]        byte_new [BYTES];
    logic [BYTES-1:0]  par_new;

    assign kind_e  = wr_kind_e'(kind);
    assign zeroing = (kind_e == WK_ZERO) || (kind_e == WK_ALLOC);

    // Decide whether this write is legal for this side.
    always_comb begin
        accept = we && (ALLOW_STORE || (kind_e == WK_FILL));
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        // Per-byte new value, enable and parity (inverted under injection).
        always_comb begin
            byte_new[b] = zeroing ? 8'h00 : wdata[8*b +: 8];
            byte_wr[b]  = accept && ((kind_e != WK_STORE) || be[b]);
            par_new[b]  = (^byte_new[b]) ^ inject;
        end
    end

    // Update array bytes and parity bits; clear everything in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]  <= '0;
                pmem[i] <= '0;
            end
        end else begin
            for (int b = 0; b < BYTES; b++) begin
                if (byte_wr[b]) begin
                    mem[wr_idx][8*b +: 8] <= byte_new[b];
                    pmem[wr_idx][b]       <= par_new[b];
                end
            end
        end
    end

    // Combinational read port.
    always_comb begin
        rdata = mem[rd_idx];
        rpar  = pmem[rd_idx];
    end
endmodule

// File: rtl/cpg_err_detect.sv
// Module: read response register and parity checker.
// Recomputes parity of the selected word, compares it with the stored bits
// and registers a one-cycle machine-check pulse when the side's check
// enable was set in the read cycle. Side and index hold until the next error.
module cpg_err_detect
    import cpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    localparam int BYTES = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 rd_side,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [DATA_W-1:0]    rdata,
    input  logic [BYTES-1:0]     rpar,
    input  logic [NUM_SIDES-1:0] chk_en,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [BYTES-1:0]     rd_par,
    output logic                 mc_err,
    output logic                 mc_err_side,
    output logic [IDX_W-1:0]     mc_err_idx
);
    logic [BYTES-1:0] calc_par;
    logic             mismatch;
    logic             hit;

    for (genvar b = 0; b < BYTES; b++) begin : g_calc
        assign calc_par[b] = ^rdata[8*b +: 8];
    end

    // Error condition seen in the read cycle.
    always_comb begin
        mismatch = |(calc_par ^ rpar);
        hit      = rd_en && chk_en[rd_side] && mismatch;
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_par   <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rdata;
                rd_par  <= rpar;
            end
        end
    end

    // Register the machine-check pulse and its location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_err      <= 1'b0;
            mc_err_side <= 1'b0;
            mc_err_idx  <= '0;
        end else begin
            mc_err <= hit;
            if (hit) begin
                mc_err_side <= rd_side;
                mc_err_idx  <= rd_idx;
            end
        end
    end
endmodule

// File: rtl/cache_parity_guard.sv
// Module: top of the cache parity guard.
// Holds the control registers, one array bank per side (the instruction
// bank accepts fills only) and the shared read checker. Assumes at most one
// write and one read per cycle.
module cache_parity_guard
    import cpg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    localparam int BYTES  = DATA_W / 8,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic              csr_side,
    input  logic [1:0]        csr_wdata,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BYTES-1:0]  wr_be,
    input  logic              rd_en,
    input  logic              rd_side,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [BYTES-1:0]  rd_par,
    output logic              mc_err,
    output logic              mc_err_side,
    output logic [IDX_W-1:0]  mc_err_idx
);
    logic [NUM_SIDES-1:0] chk_en;
    logic [NUM_SIDES-1:0] inj_en;
    logic [DATA_W-1:0]    bank_rdata [NUM_SIDES];
    logic [BYTES-1:0]     bank_rpar  [NUM_SIDES];
    logic [DATA_W-1:0]    sel_rdata;
    logic [BYTES-1:0]     sel_rpar;

    cpg_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_side  (csr_side),
        .csr_wdata (csr_wdata),
        .chk_en    (chk_en),
        .inj_en    (inj_en)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (wr_side == s[0]);

        cpg_bank #(
            .DATA_W      (DATA_W),
            .DEPTH       (DEPTH),
            .ALLOW_STORE (s == SIDE_D)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (bank_we),
            .kind   (wr_kind),
            .wr_idx (wr_idx),
            .wdata  (wr_data),
            .be     (wr_be),
            .inject (inj_en[s]),
            .rd_idx (rd_idx),
            .rdata  (bank_rdata[s]),
            .rpar   (bank_rpar[s])
        );
    end

    // Pick the read word of the addressed side.
    always_comb begin
        sel_rdata = bank_rdata[rd_side];
        sel_rpar  = bank_rpar[rd_side];
    end

    cpg_err_detect #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_side     (rd_side),
        .rd_idx      (rd_idx),
        .rdata       (sel_rdata),
        .rpar        (sel_rpar),
        .chk_en      (chk_en),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rd_par      (rd_par),
        .mc_err      (mc_err),
        .mc_err_side (mc_err_side),
        .mc_err_idx  (mc_err_idx)
    );
endmodule

// File: rtl/cpg_sva.sv
// Checker: temporal properties of the parity guard, bound to the top.
// Assumes it sees the control register outputs of the top module.
module cpg_sva #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        chk_en,
    input logic [1:0]        inj_en,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [BYTES-1:0]  rd_par,
    input logic              mc_err,
    input logic              mc_err_side
);
    logic [BYTES-1:0] out_calc;
    for (genvar b = 0; b < BYTES; b++) begin : g_oc
        assign out_calc[b] = ^rd_data[8*b +: 8];
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (chk_en == 2'b00 && inj_en == 2'b00 && !mc_err && !rd_valid));

    p_inject_needs_check_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((inj_en & ~chk_en) == 2'b00));

    p_valid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_valid_without_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_err_with_response_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mc_err |-> rd_valid);

    p_err_means_mismatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mc_err |-> (out_calc != rd_par));

    p_err_needs_check_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mc_err |-> (mc_err_side ? $past(chk_en[1]) : $past(chk_en[0])));
endmodule

bind cache_parity_guard cpg_sva #(.DATA_W(DATA_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_en      (chk_en),
    .inj_en      (inj_en),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_par      (rd_par),
    .mc_err      (mc_err),
    .mc_err_side (mc_err_side)
);

// File: tb/cache_parity_guard_tb.sv
`timescale 1ns/1ps
module cache_parity_guard_tb;
    localparam int DW = 32;
    localparam int DP = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 0, csr_side = 0;
    logic [1:0]    csr_wdata = 0;
    logic          wr_en = 0, wr_side = 0;
    logic [1:0]    wr_kind = 0;
    logic [IW-1:0] wr_idx = 0;
    logic [DW-1:0] wr_data = 0;
    logic [3:0]    wr_be = 0;
    logic          rd_en = 0, rd_side = 0;
    logic [IW-1:0] rd_idx = 0;
    logic          rd_valid, mc_err, mc_err_side;
    logic [DW-1:0] rd_data;
    logic [3:0]    rd_par;
    logic [IW-1:0] mc_err_idx;

    int n_chk = 0, n_fail = 0;
    bit started = 0, done = 0;

    always #10 clk = ~clk;

    cache_parity_guard #(.DATA_W(DW), .DEPTH(DP)) u_dut (.*);

    // ---------------- reference model ----------------
    logic [DW-1:0] m_data [2][DP];
    logic [3:0]    m_par  [2][DP];
    bit            m_chk [2];
    bit            m_inj [2];
    logic          e_valid, e_err, e_side;
    logic [DW-1:0] e_data;
    logic [3:0]    e_par;
    logic [IW-1:0] e_idx;

    function automatic logic [3:0] even_par(input logic [DW-1:0] w);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) p[b] = ^w[8*b +: 8];
        return p;
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                m_chk[s] = 0; m_inj[s] = 0;
                for (int i = 0; i < DP; i++) begin m_data[s][i] = 0; m_par[s][i] = 0; end
            end
            e_valid = 0; e_err = 0; e_side = 0; e_idx = 0; e_data = 0; e_par = 0;
        end else begin
            // read sees state before this edge's updates
            e_valid = rd_en;
            e_err   = 0;
            if (rd_en) begin
                e_data = m_data[rd_side][rd_idx];
                e_par  = m_par[rd_side][rd_idx];
                if (m_chk[rd_side] && (even_par(e_data) != e_par)) begin
                    e_err = 1; e_side = rd_side; e_idx = rd_idx;
                end
            end
            if (wr_en && (wr_side == 1'b1 || wr_kind == 2'd0)) begin
                for (int b = 0; b < 4; b++) begin
                    if (wr_kind != 2'd1 || wr_be[b]) begin
                        logic [7:0] nb;
                        nb = (wr_kind >= 2'd2) ? 8'h00 : wr_data[8*b +: 8];
                        m_data[wr_side][wr_idx][8*b +: 8] = nb;
                        m_par[wr_side][wr_idx][b] = (^nb) ^ m_inj[wr_side];
                    end
                end
            end
            if (csr_we) begin
                m_chk[csr_side] = csr_wdata[0];
                m_inj[csr_side] = csr_wdata[0] & csr_wdata[1];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock.
    always @(negedge clk) begin
        if (started && !done) begin
            check(rd_valid === e_valid, "R8 rd_valid", 64'(rd_valid), 64'(e_valid));
            check(mc_err === e_err, "R9 mc_err", 64'(mc_err), 64'(e_err));
            if (e_valid) begin
                check(rd_data === e_data, "R8 rd_data", 64'(rd_data), 64'(e_data));
                check(rd_par === e_par, "R3 rd_par", 64'(rd_par), 64'(e_par));
            end
            if (e_err) begin
                check(mc_err_side === e_side, "R9 side", 64'(mc_err_side), 64'(e_side));
                check(mc_err_idx === e_idx, "R9 idx", 64'(mc_err_idx), 64'(e_idx));
            end
        end
    end

    // ---------------- stimulus tasks (start and end at a negedge) ----------------
    task automatic csr_wr(input bit side, input logic [1:0] v);
        csr_we = 1; csr_side = side; csr_wdata = v;
        @(negedge clk);
        csr_we = 0;
    endtask

    task automatic do_wr(input bit side, input logic [1:0] k, input int idx,
                         input logic [DW-1:0] d, input logic [3:0] be);
        wr_en = 1; wr_side = side; wr_kind = k; wr_idx = IW'(idx); wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input bit side, input int idx, input logic [DW-1:0] xd,
                          input logic [3:0] xp, input bit xe, input string req);
        rd_en = 1; rd_side = side; rd_idx = IW'(idx);
        @(negedge clk);
        rd_en = 0;
        check(rd_data === xd, req, 64'(rd_data), 64'(xd));
        check(rd_par === xp, req, 64'(rd_par), 64'(xp));
        check(mc_err === xe, req, 64'(mc_err), 64'(xe));
        if (xe) begin
            check(mc_err_side === side, req, 64'(mc_err_side), 64'(side));
            check(mc_err_idx === IW'(idx), req, 64'(mc_err_idx), 64'(idx));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(rd_valid === 0 && mc_err === 0, "R1 reset outputs", 64'({rd_valid, mc_err}), 0);
        rst_n = 1;
        @(negedge clk);
        rd_chk(1, 0, 32'h0, 4'h0, 0, "R1 reset array D");
        rd_chk(0, 15, 32'h0, 4'h0, 0, "R1 reset array I");

        // R3: plain fill, even parity per byte
        do_wr(0, 2'd0, 3, 32'h01A5_7F00, 4'h0);
        rd_chk(0, 3, 32'h01A5_7F00, even_par(32'h01A5_7F00), 0, "R3 even parity");

        // R2: inject without check is dropped
        csr_wr(0, 2'b10);
        do_wr(0, 2'd0, 4, 32'h1234_5678, 4'h0);
        rd_chk(0, 4, 32'h1234_5678, even_par(32'h1234_5678), 0, "R2 inject w/o check");

        // R4: instruction inject inverts fill parity and raises error (R9)
        csr_wr(0, 2'b11);
        do_wr(0, 2'd0, 5, 32'hDEAD_BEEF, 4'h0);
        rd_chk(0, 5, 32'hDEAD_BEEF, ~even_par(32'hDEAD_BEEF), 1, "R4 I fill inverted R9");
        // R4: non-fill writes to instruction side ignored
        do_wr(0, 2'd1, 3, 32'hFFFF_FFFF, 4'hF);
        do_wr(0, 2'd2, 3, 32'h0, 4'h0);
        rd_chk(0, 3, 32'h01A5_7F00, even_par(32'h01A5_7F00), 0, "R4 I store ignored");

        // R5: data fill inverted
        csr_wr(1, 2'b01);
        do_wr(1, 2'd0, 1, 32'h0F0F_3C3C, 4'h0);
        rd_chk(1, 1, 32'h0F0F_3C3C, even_par(32'h0F0F_3C3C), 0, "R5 D fill normal");
        csr_wr(1, 2'b11);
        do_wr(1, 2'd0, 2, 32'h8001_0203, 4'h0);
        rd_chk(1, 2, 32'h8001_0203, ~even_par(32'h8001_0203), 1, "R5 D fill inverted");

        // R6/R7: masked store with inject: bytes 0 and 2 written, inverted
        do_wr(1, 2'd1, 1, 32'hAA01_BB07, 4'b0101);
        begin
            logic [DW-1:0] w; logic [3:0] p;
            w = 32'h0F01_3C07;
            p = even_par(32'h0F0F_3C3C);
            p[0] = ~(^w[7:0]); p[2] = ~(^w[23:16]);
            rd_chk(1, 1, w, p, 1, "R6 R7 masked store inverted");
        end
        // R6/R7: zero and allocate write zeros with inverted parity
        do_wr(1, 2'd0, 7, 32'hFFFF_0000, 4'h0);
        do_wr(1, 2'd2, 7, 32'h1234_5678, 4'h0);
        rd_chk(1, 7, 32'h0, 4'hF, 1, "R6 R7 zero inverted");
        do_wr(1, 2'd3, 8, 32'h1234_5678, 4'h0);
        rd_chk(1, 8, 32'h0, 4'hF, 1, "R6 R7 alloc inverted");

        // R10: checking off hides errors
        csr_wr(1, 2'b00);
        rd_chk(1, 2, 32'h8001_0203, ~even_par(32'h8001_0203), 0, "R10 no check");
        // R11: stored bad parity persists; error returns when checking re-enabled
        csr_wr(1, 2'b01);
        rd_chk(1, 2, 32'h8001_0203, ~even_par(32'h8001_0203), 1, "R11 persists");
        do_wr(1, 2'd0, 2, 32'h8001_0203, 4'h0);
        rd_chk(1, 2, 32'h8001_0203, even_par(32'h8001_0203), 0, "R11 repaired");

        // R8: read in the same cycle as a write to the same index sees old word
        wr_en = 1; wr_side = 1; wr_kind = 0; wr_idx = 9; wr_data = 32'h5555_AAAA;
        rd_en = 1; rd_side = 1; rd_idx = 9;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check(rd_valid === 1 && rd_data === 32'h0, "R8 read before write",
              64'(rd_data), 64'h0);
        rd_chk(1, 9, 32'h5555_AAAA, even_par(32'h5555_AAAA), 0, "R8 next read");

        // Random phase, compared by the model every clock
        for (int n = 0; n < 3000; n++) begin
            csr_we = ($urandom_range(0, 15) == 0);
            csr_side = 1'($urandom); csr_wdata = 2'($urandom);
            wr_en = 1'($urandom); wr_side = 1'($urandom); wr_kind = 2'($urandom);
            wr_idx = IW'($urandom); wr_data = $urandom; wr_be = 4'($urandom);
            rd_en = 1'($urandom); rd_side = 1'($urandom);
            rd_idx = ($urandom_range(0, 3) == 0) ? wr_idx : IW'($urandom);
            @(negedge clk);
        end
        csr_we = 0; wr_en = 0; rd_en = 0;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule